// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

The block counts ticks from a slow free-running oscillator and, unless software restarts it in time, signals a timeout. The timeout raises an interrupt request, a system reset request, or an interrupt followed by a reset on the next timeout. The mode comes from two enable bits in an 8-bit control register. A separate status register holds a sticky flag that records a reset caused by the watchdog.

Some changes to the control register are guarded, because a runaway program must not be able to switch the watchdog off by accident. Lowering the reset enable or changing the timeout period needs an unlock write first. The change must then follow within a short window of clock cycles. The sticky reset flag keeps the reset enable set until software clears the flag. An always-on lock input pins the block in reset mode.

The block is driven by a simple one-cycle register bus with a one-bit address. Address 0 selects control and address 1 selects status. Read data is combinational.

Top module: `wdt_core`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and both `irq` and `sys_rst_req` are low.
- R2: Control register bit positions: bit 7 is the interrupt flag, bit 6 the interrupt enable, bit 5 period bit 3, bit 4 the change enable, bit 3 the reset enable, and bits 2..0 period bits 2..0. The status register bit 0 is the watchdog reset flag and its other bits read 0.
- R3: Outside an unlock window, writes to the period bits are ignored and a write of 0 to reset enable is ignored. A write of 1 to reset enable is always accepted.
- R4: A control write with bit 4 and bit 3 both 1 opens an unlock window lasting UNLOCK_CYC (default 4) cycles, during which bit 4 reads 1. One control write inside the window updates reset enable and the period bits, and it closes the window. Once the window has expired, bit 4 reads 0 and such a write is ignored again.
- R5: A timeout occurs BASE_TICKS << code oscillator ticks after the counter was last cleared, where code is the 4-bit period value. Codes above 9 behave as code 9. The counter restarts from zero after each timeout.
- R6: A `kick` pulse clears the tick counter. A kick in the same cycle as the final tick prevents that timeout.
- R7: With both enables clear, the counter does not run and no timeout event occurs.
- R8: With only the interrupt enable set, a timeout sets the interrupt flag. `irq` equals the flag, and writing 1 to bit 7 clears it.
- R9: With only the reset enable set, a timeout gives a one-cycle `sys_rst_req` pulse and sets the status reset flag.
- R10: With both enables set, the first timeout sets the interrupt flag and clears the interrupt enable. The next timeout then requests a system reset.
- R11: While the reset flag is set, reset enable reads 1 and cannot be cleared, even inside an unlock window. Writing 0 to status bit 0 clears the flag. Writing 1 to it has no effect.
- R12: While `lock_on` is high, reset enable reads 1 and interrupt enable reads 0, whatever is written, so every timeout requests a system reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator, synchronous to clk |
| kick | input | 1 | Restart strobe that clears the counter |
| lock_on | input | 1 | Always-on lock that forces reset mode |
| irq | output | 1 | Interrupt request, equal to the interrupt flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `osc_tick` and `kick` are clean single-cycle strobes already synchronous to `clk`. They also assume the period code changes only while the counter is stopped or freshly cleared, so that a running count never straddles two limits. The bench keeps within this: it sets the period with the oscillator tick held low, then restarts the counter with a kick in the same cycle the tick stream starts. It holds `lock_on` constant within each scenario and applies a fresh reset between scenarios, so no timeout left over from one mode leaks into the next.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BIT_IFLAG  = 7;
    localparam int BIT_IEN    = 6;
    localparam int BIT_PHI    = 5;
    localparam int BIT_CHG    = 4;
    localparam int BIT_REN    = 3;
    localparam int BIT_RFLAG  = 0;
    localparam int MAX_CODE   = 9;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int BASE_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic       run_i,
    input  logic [3:0] code_i,
    output logic       timeout_o
);
    import wdt_pkg::*;

    localparam int CW = $clog2(BASE_TICKS) + MAX_CODE + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [3:0]    code_c;
    logic [CW-1:0] limit;

    always_comb begin
        code_c    = (code_i > 4'(MAX_CODE)) ? 4'(MAX_CODE) : code_i;
        limit     = CW'(BASE_TICKS) << code_c;
        timeout_o = run_i && tick_i && !kick_i && (cnt_q >= limit - CW'(1));
        cnt_d     = cnt_q;
        if (!run_i || kick_i || timeout_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (cnt_q == '0));

    assert_restart_after_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (cnt_q == '0));

    assert_idle_stays_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter int UNLOCK_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic       wr_stat_i,
    input  logic [7:0] wdata_i,
    input  logic       lock_i,
    input  logic       timeout_i,
    output logic [7:0] ctrl_rd_o,
    output logic [7:0] stat_rd_o,
    output logic [3:0] code_o,
    output logic       run_o,
    output logic       irq_o,
    output logic       rst_req_o
);
    import wdt_pkg::*;

    localparam int WW = $clog2(UNLOCK_CYC + 1);

    typedef struct packed {
        logic          iflag;
        logic          ien;
        logic          ren;
        logic [3:0]    code;
        logic [WW-1:0] win;
        logic          rflag;
        logic          rst_req;
    } st_t;

    st_t  d, q;
    logic win_open, eff_ren, eff_ien;

    always_comb begin
        win_open = (q.win != '0);
        eff_ren  = q.ren || q.rflag || lock_i;
        eff_ien  = q.ien && !lock_i;

        d         = q;
        d.rst_req = 1'b0;
        if (win_open) d.win = q.win - WW'(1);

        if (wr_ctrl_i) begin
            if (wdata_i[BIT_IFLAG]) d.iflag = 1'b0;
            d.ien = wdata_i[BIT_IEN];
            if (win_open) begin
                d.ren  = wdata_i[BIT_REN] || q.rflag;
                d.code = {wdata_i[BIT_PHI], wdata_i[2:0]};
                d.win  = '0;
            end else begin
                if (wdata_i[BIT_REN]) d.ren = 1'b1;
                if (wdata_i[BIT_REN] && wdata_i[BIT_CHG]) d.win = WW'(UNLOCK_CYC);
            end
        end

        if (wr_stat_i && !wdata_i[BIT_RFLAG]) d.rflag = 1'b0;

        if (timeout_i) begin
            if (eff_ien) begin
                d.iflag = 1'b1;
                if (eff_ren) d.ien = 1'b0;
            end else if (eff_ren) begin
                d.rst_req = 1'b1;
                d.rflag   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_rd_o = {q.iflag, eff_ien, q.code[3], win_open, eff_ren, q.code[2:0]};
        stat_rd_o = 8'(q.rflag);
        code_o    = q.code;
        run_o     = eff_ren || eff_ien;
        irq_o     = q.iflag;
        rst_req_o = q.rst_req;
    end

    assert_code_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.code) |-> $past(win_open));

    assert_ren_clear_guarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ren) |-> ($past(win_open) && !$past(q.rflag)));

    assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    assert_flag_with_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> q.rflag);

    assert_combined_first_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && eff_ien && eff_ren) |=> (q.iflag && !q.ien && !rst_req_o));

    assert_lock_resets_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && lock_i) |=> rst_req_o);

    assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> !timeout_i);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int BASE_TICKS = 2048,
    parameter int UNLOCK_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       osc_tick,
    input  logic       kick,
    input  logic       lock_on,
    output logic       irq,
    output logic       sys_rst_req
);
    import wdt_pkg::*;

    logic       wr_ctrl, wr_stat, run, timeout;
    logic [3:0] code;
    logic [7:0] ctrl_rd, stat_rd;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == ADDR_STAT);
    assign bus_rdata = (bus_addr == ADDR_STAT) ? stat_rd : ctrl_rd;

    wdt_ctrl #(.UNLOCK_CYC(UNLOCK_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_stat_i (wr_stat),
        .wdata_i   (bus_wdata),
        .lock_i    (lock_on),
        .timeout_i (timeout),
        .ctrl_rd_o (ctrl_rd),
        .stat_rd_o (stat_rd),
        .code_o    (code),
        .run_o     (run),
        .irq_o     (irq),
        .rst_req_o (sys_rst_req)
    );

    wdt_count #(.BASE_TICKS(BASE_TICKS)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (osc_tick),
        .kick_i    (kick),
        .run_i     (run),
        .code_i    (code),
        .timeout_o (timeout)
    );
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       osc_tick = 1'b0;
    logic       kick = 1'b0;
    logic       lock_on = 1'b0;
    logic       irq, sys_rst_req;

    int unsigned cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        int unsigned at;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    wdt_core #(.BASE_TICKS(BASE), .UNLOCK_CYC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_tick(osc_tick),
        .kick(kick), .lock_on(lock_on), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected timeout events and compares kind and cycle.
    logic irq_prev = 1'b0, rst_prev = 1'b0;
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            bit seen;
            seen = (k == 0) ? (irq && !irq_prev) : (sys_rst_req && !rst_prev);
            if (seen && rst_n) begin
                if (exp_q.size() == 0) begin
                    check("unexpected event", k, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.req, " kind"}, k, e.kind);
                    check({e.req, " cycle"}, int'(cyc), int'(e.at));
                end
            end
        end
        irq_prev <= irq;
        rst_prev <= sys_rst_req;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; osc_tick = 1'b0; kick = 1'b0; lock_on = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] dat);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = dat;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Driver: kicks, starts ticking and pushes the expected events.
    task automatic start_run(int first_kind, int lim, int second_kind, string req,
                             output int unsigned s);
        exp_t e;
        @(negedge clk);
        kick = 1'b1; osc_tick = 1'b1; s = cyc;
        e.kind = first_kind; e.at = s + 1 + lim; e.req = req;
        exp_q.push_back(e);
        if (second_kind >= 0) begin
            e.kind = second_kind; e.at = s + 1 + 2 * lim;
            exp_q.push_back(e);
        end
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned s;
        do_reset();

        // R1 reset state
        rd(1'b0, v); check("R1 ctrl", v, 8'h00);
        rd(1'b1, v); check("R1 status", v, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 rst_req", sys_rst_req, 0);

        // R3 period and reset-enable clear without unlock
        wr(1'b0, 8'h27); rd(1'b0, v); check("R3 period ignored", v, 8'h00);
        wr(1'b0, 8'h08); rd(1'b0, v); check("R3 ren set", v, 8'h08);
        wr(1'b0, 8'h00); rd(1'b0, v); check("R3 ren clear ignored", v, 8'h08);

        // R4 and R2 unlock then guarded write
        wr(1'b0, 8'h18); rd(1'b0, v); check("R4 chg reads 1", v, 8'h18);
        wr(1'b0, 8'h21); rd(1'b0, v); check("R2 R4 guarded write", v, 8'h21);

        // R4 window expiry
        do_reset();
        wr(1'b0, 8'h18);
        repeat (6) @(negedge clk);
        rd(1'b0, v); check("R4 window expired", v, 8'h08);
        wr(1'b0, 8'h01); rd(1'b0, v); check("R4 late write ignored", v, 8'h08);

        // R5 R8 code 0, interrupt only
        do_reset();
        wr(1'b0, 8'h40);
        start_run(0, BASE, -1, "R5 R8 code0 irq", s);
        drain();
        rd(1'b0, v); check("R8 flag set", v, 8'hC0);
        check("R8 irq level", irq, 1);
        wr(1'b0, 8'hC0); rd(1'b0, v); check("R8 flag cleared", v, 8'h40);
        check("R8 irq low", irq, 0);

        // R5 code 2
        wr(1'b0, 8'h18); wr(1'b0, 8'h42);
        rd(1'b0, v); check("R5 code2 readback", v, 8'h42);
        start_run(0, BASE << 2, -1, "R5 code2 irq", s);
        drain();
        wr(1'b0, 8'hC0);

        // R5 code 12 acts as 9
        wr(1'b0, 8'h18); wr(1'b0, 8'h64);
        rd(1'b0, v); check("R5 code12 readback", v, 8'h64);
        start_run(0, BASE << 9, -1, "R5 code12 clamp", s);
        drain();

        // R7 stopped
        do_reset();
        osc_tick = 1'b1;
        repeat (200) @(negedge clk);
        osc_tick = 1'b0;
        check("R7 no irq", irq, 0);
        rd(1'b1, v); check("R7 no flag", v, 8'h00);

        // R9 reset only, R6 kick
        wr(1'b0, 8'h08);
        start_run(1, BASE, -1, "R6 R9 reset", s);
        drain();
        check("R9 one-cycle pulse", sys_rst_req, 0);
        rd(1'b1, v); check("R9 flag set", v, 8'h01);

        // R11 flag holds reset enable
        wr(1'b0, 8'h18); wr(1'b0, 8'h00);
        rd(1'b0, v); check("R11 ren held", v, 8'h08);
        wr(1'b1, 8'h01); rd(1'b1, v); check("R11 write 1 no effect", v, 8'h01);
        wr(1'b1, 8'h00); rd(1'b1, v); check("R11 flag cleared", v, 8'h00);
        wr(1'b0, 8'h18); wr(1'b0, 8'h00);
        rd(1'b0, v); check("R11 ren cleared", v, 8'h00);

        // R6 kick before final tick prevents timeout
        wr(1'b0, 8'h40);
        @(negedge clk); kick = 1'b1; osc_tick = 1'b1;
        @(negedge clk); kick = 1'b0;
        repeat (BASE - 2) @(negedge clk);
        kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        osc_tick = 1'b0;
        check("R6 kick prevents irq", irq, 0);
        do_reset();

        // R10 combined mode
        wr(1'b0, 8'h48);
        start_run(0, BASE, 1, "R10 combined", s);
        while (cyc != s + 2 + BASE) @(negedge clk);
        rd(1'b0, v); check("R10 ien cleared", v, 8'h88);
        drain();
        rd(1'b1, v); check("R10 reset flag", v, 8'h01);

        // R12 lock
        do_reset();
        lock_on = 1'b1;
        wr(1'b0, 8'h40); rd(1'b0, v); check("R12 forced mode", v, 8'h08);
        start_run(1, BASE, -1, "R12 lock reset", s);
        drain();
        check("R12 no irq", irq, 0);
        lock_on = 1'b0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule